// File: doc/BRIEF.md
# Alternate-Byte Peripheral Transfer Unit

This unit carries a word or a longword between a CPU data register and memory as a string of single-byte accesses. Consecutive bytes land on addresses two apart, so a peripheral that is wired to only one byte lane of a 16-bit bus still sees every byte. The highest byte goes out first. The caller supplies the decoded opcode, the current value of the named address register, a 16-bit signed displacement and the current value of the named data register, then pulses `start`.

The unit latches those inputs and then runs one request/acknowledge handshake per byte on its byte-wide memory port. It finishes with a one-cycle `done` pulse. In the read direction, that pulse also carries the register value to write back and the index of the register to write. The nominal instruction cost in cycles is reported with `done`.

The controller has three states. `ST_IDLE` goes to `ST_XFER` when `start` is high. `ST_XFER` stays where it is until a byte is acknowledged. It moves to `ST_DONE` when the acknowledged byte is the last one. `ST_DONE` always returns to `ST_IDLE` one cycle later.

Top module: `alt_byte_xfer`

## Requirements
- R1: Opcode bits 11..9 select the data register, which is returned on `wb_sel`. Bits 2..0 select the address register and appear combinationally on `areg_sel`. Bit 7 = 1 means register to memory (`mem_we` = 1). Bit 6 = 1 means longword.
- R2: The first byte address equals the address register value plus the sign-extended 16-bit displacement, modulo 2^32.
- R3: Byte k of a transfer uses address EA + 2·k. In the write direction, byte 0 is the most significant byte of the operand: bits 31..24 for a longword, bits 15..8 for a word.
- R4: A word transfer makes exactly 2 byte accesses and a longword transfer makes exactly 4.
- R5: While a request is not yet acknowledged, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady.
- R6: A longword read returns the four bytes with byte 0 in bits 31..24 and byte 3 in bits 7..0.
- R7: A word read replaces only bits 15..0 (byte 0 in 15..8). Bits 31..16 keep the data register value latched at start.
- R8: `done` is high for exactly one cycle, in the cycle after the last acknowledge. `wb_en` is high only together with `done`, and only for reads.
- R9: `cost` reads 16 for a word and 24 for a longword while `done` is high.
- R10: `start` is ignored while `busy` is high. Opcode, address, displacement and data changes during a transfer have no effect on it.
- R11: In the write direction, `result` at `done` equals the data register value latched at start, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| opcode | input | 16 | Decoded instruction word |
| areg_val | input | 32 | Value of the selected address register |
| disp | input | 16 | Signed displacement |
| dreg_val | input | 32 | Value of the selected data register |
| areg_sel | output | 3 | Address register index taken from the opcode |
| busy | output | 1 | A transfer is in progress |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| done | output | 1 | Transfer complete pulse |
| wb_en | output | 1 | Write `result` back to the data register |
| wb_sel | output | 3 | Data register index for write-back |
| result | output | 32 | Assembled register value |
| cost | output | 5 | Instruction cost in cycles |

## Verification
The bench tries all four combinations of direction and size.

- Reads and writes show whether `mem_we` and the write-back path follow bit 7.
- Word and longword runs show whether the byte count, the preserved upper half and the cost follow bit 6.

Displacements vary:

- a positive displacement,
- a negative displacement,
- one that wraps the 32-bit address.

Together these show whether sign extension and address stepping are correct. Acknowledge latencies from zero to several cycles show whether the request is held steady and whether an unacknowledged byte is ever counted. Runs that re-pulse `start` with changed inputs during a transfer show whether anything latched at start can be disturbed.

// File: rtl/abx_pkg.sv
package abx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_DONE = 2'd2
    } abx_state_e;

    localparam int OP_DIR_BIT  = 7;
    localparam int OP_LONG_BIT = 6;
    localparam int OP_DREG_LSB = 9;
    localparam int OP_AREG_LSB = 0;
    localparam int REG_IDX_W   = 3;

endpackage

// File: rtl/abx_ctrl.sv
module abx_ctrl
    import abx_pkg::*;
#(
    parameter int CNT_W      = 2,
    parameter int WORD_BYTES = 2,
    parameter int LONG_BYTES = 4,
    parameter int COST_W     = 5,
    parameter int WORD_COST  = 16,
    parameter int LONG_COST  = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [15:0]          opcode,
    input  logic                 mem_ack,
    output logic [CNT_W-1:0]     idx,
    output logic [CNT_W-1:0]     last_idx,
    output logic                 launch,
    output logic                 step,
    output logic                 dir_q,
    output logic                 long_q,
    output logic [REG_IDX_W-1:0] dsel_q,
    output logic                 busy,
    output logic                 req,
    output logic                 done,
    output logic                 wb_en,
    output logic [COST_W-1:0]    cost
);

    abx_state_e state_q, state_d;
    logic       is_last;

    assign last_idx = long_q ? CNT_W'(LONG_BYTES - 1) : CNT_W'(WORD_BYTES - 1);
    assign is_last  = (idx == last_idx);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)              state_d = ST_XFER;
            ST_XFER: if (mem_ack && is_last) state_d = ST_DONE;
            ST_DONE:                         state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        req    = (state_q == ST_XFER);
        done   = (state_q == ST_DONE);
        launch = (state_q == ST_IDLE) && start;
        step   = (state_q == ST_XFER) && mem_ack;
        wb_en  = done && !dir_q;
        cost   = long_q ? COST_W'(LONG_COST) : COST_W'(WORD_COST);
    end

    // latched fields and byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx    <= '0;
            dir_q  <= 1'b0;
            long_q <= 1'b0;
            dsel_q <= '0;
        end else if (launch) begin
            idx    <= '0;
            dir_q  <= opcode[OP_DIR_BIT];
            long_q <= opcode[OP_LONG_BIT];
            dsel_q <= opcode[OP_DREG_LSB +: REG_IDX_W];
        end else if (step && !is_last) begin
            idx    <= idx + 1'b1;
        end
    end

endmodule

// File: rtl/abx_agen.sv
module abx_agen #(
    parameter int AW     = 32,
    parameter int DISP_W = 16,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [AW-1:0]     base,
    input  logic [DISP_W-1:0] disp,
    input  logic [CNT_W-1:0]  idx,
    output logic [AW-1:0]     addr
);

    localparam int EXT_W = AW - DISP_W;

    logic [AW-1:0] ea_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ea_q <= '0;
        else if (launch) ea_q <= base + {{EXT_W{disp[DISP_W-1]}}, disp};
    end

    assign addr = ea_q + AW'({idx, 1'b0});

endmodule

// File: rtl/abx_lane.sv
module abx_lane #(
    parameter int DW    = 32,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             step,
    input  logic             dir_q,
    input  logic             long_q,
    input  logic [DW-1:0]    data_in,
    input  logic [7:0]       rdata,
    input  logic [CNT_W-1:0] idx,
    input  logic [CNT_W-1:0] last_idx,
    output logic [7:0]       wdata,
    output logic [DW-1:0]    result
);

    localparam int HALF = DW / 2;

    logic [DW-1:0]    hold_q;
    logic [DW-1:0]    acc_q;
    logic [CNT_W-1:0] from_low;
    logic [DW-1:0]    shifted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            acc_q  <= '0;
        end else if (launch) begin
            hold_q <= data_in;
            acc_q  <= '0;
        end else if (step) begin
            acc_q  <= {acc_q[DW-9:0], rdata};
        end
    end

    // byte position counted from the least significant end
    assign from_low = last_idx - idx;
    assign shifted  = hold_q >> {from_low, 3'b000};
    assign wdata    = shifted[7:0];

    always_comb begin
        if (dir_q)       result = hold_q;
        else if (long_q) result = acc_q;
        else             result = {hold_q[DW-1:HALF], acc_q[HALF-1:0]};
    end

endmodule

// File: rtl/alt_byte_xfer.sv
module alt_byte_xfer
    import abx_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int DISP_W    = 16,
    parameter int COST_W    = 5,
    parameter int WORD_COST = 16,
    parameter int LONG_COST = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       opcode,
    input  logic [AW-1:0]     areg_val,
    input  logic [DISP_W-1:0] disp,
    input  logic [DW-1:0]     dreg_val,
    output logic [2:0]        areg_sel,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              done,
    output logic              wb_en,
    output logic [2:0]        wb_sel,
    output logic [DW-1:0]     result,
    output logic [COST_W-1:0] cost
);

    localparam int LONG_BYTES = DW / 8;
    localparam int WORD_BYTES = LONG_BYTES / 2;
    localparam int CNT_W      = $clog2(LONG_BYTES);

    logic [CNT_W-1:0] idx, last_idx;
    logic             launch, step, dir_q, long_q;

    assign areg_sel = opcode[OP_AREG_LSB +: REG_IDX_W];

    abx_ctrl #(
        .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES), .LONG_BYTES(LONG_BYTES),
        .COST_W(COST_W), .WORD_COST(WORD_COST), .LONG_COST(LONG_COST)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .mem_ack(mem_ack), .idx(idx), .last_idx(last_idx),
        .launch(launch), .step(step), .dir_q(dir_q), .long_q(long_q),
        .dsel_q(wb_sel), .busy(busy), .req(mem_req), .done(done),
        .wb_en(wb_en), .cost(cost)
    );

    abx_agen #(.AW(AW), .DISP_W(DISP_W), .CNT_W(CNT_W)) u_agen (
        .clk(clk), .rst_n(rst_n), .launch(launch), .base(areg_val),
        .disp(disp), .idx(idx), .addr(mem_addr)
    );

    abx_lane #(.DW(DW), .CNT_W(CNT_W)) u_lane (
        .clk(clk), .rst_n(rst_n), .launch(launch), .step(step),
        .dir_q(dir_q), .long_q(long_q), .data_in(dreg_val),
        .rdata(mem_rdata), .idx(idx), .last_idx(last_idx),
        .wdata(mem_wdata), .result(result)
    );

    assign mem_we = mem_req && dir_q;

endmodule

// File: rtl/abx_chk.sv
module abx_chk #(
    parameter int AW = 32,
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic [15:0]   opcode,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_wdata,
    input logic          done,
    input logic          wb_en
);

    logic [3:0] acks;
    logic       long_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acks   <= '0;
            long_c <= 1'b0;
        end else if (start && !busy) begin
            acks   <= '0;
            long_c <= opcode[6];
        end else if (mem_req && mem_ack) begin
            acks   <= acks + 1'b1;
        end
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) + AW'(2)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // R4
    byte_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acks == (long_c ? 4'(NB) : 4'(NB / 2))));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && start) |=> mem_req);

endmodule

bind alt_byte_xfer abx_chk #(.AW(AW), .NB(DW / 8)) u_abx_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .opcode(opcode),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .wb_en(wb_en)
);

// File: tb/alt_byte_xfer_bench.sv
module alt_byte_xfer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] opcode;
    logic [31:0] areg_val;
    logic [15:0] disp;
    logic [31:0] dreg_val;
    logic [2:0]  areg_sel;
    logic        busy, mem_req, mem_we, mem_ack, done, wb_en;
    logic [31:0] mem_addr, result;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [2:0]  wb_sel;
    logic [4:0]  cost;

    always #10 clk = ~clk;

    alt_byte_xfer u_alt_byte_xfer (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .areg_val(areg_val), .disp(disp), .dreg_val(dreg_val),
        .areg_sel(areg_sel), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .done(done), .wb_en(wb_en), .wb_sel(wb_sel),
        .result(result), .cost(cost)
    );

    int checks = 0;
    int errors = 0;

    // reference model state
    int          m_phase = 0;
    int          m_k, m_n, m_wc, m_delay;
    bit          m_dir, m_long;
    logic [2:0]  m_dsel;
    logic [31:0] m_ea, m_hold, m_acc;

    function automatic logic [7:0] mfun(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] ea_k, expv;
        chk("R1 areg_sel", 32'(areg_sel), 32'(opcode[2:0]));
        chk("R10 busy", 32'(busy), 32'(m_phase != 0));
        chk("R5 mem_req", 32'(mem_req), 32'(m_phase == 1));
        chk("R8 done (R4 byte count)", 32'(done), 32'(m_phase == 2));
        chk("R8 wb_en", 32'(wb_en), 32'(m_phase == 2 && !m_dir));
        if (m_phase == 1) begin
            ea_k = m_ea + 32'(2 * m_k);
            chk(m_k == 0 ? "R2 first address" : "R3 byte address", mem_addr, ea_k);
            chk("R1 direction", 32'(mem_we), 32'(m_dir));
            if (m_dir) begin
                expv = m_long ? (m_hold >> (24 - 8 * m_k)) : (m_hold >> (8 - 8 * m_k));
                chk("R3 byte order", 32'(mem_wdata), 32'(expv[7:0]));
            end
        end
        if (m_phase == 2) begin
            if (m_dir)       chk("R11 write result", result, m_hold);
            else if (m_long) chk("R6 long read", result, m_acc);
            else             chk("R7 word read", result, {m_hold[31:16], m_acc[15:0]});
            chk("R9 cost", 32'(cost), m_long ? 32'd24 : 32'd16);
            chk("R1 wb_sel", 32'(wb_sel), 32'(m_dsel));
        end
    endtask

    task automatic tick(bit st);
        logic [7:0] rd;
        bit         ak;
        start = st;
        ak = (m_phase == 1) && (m_wc >= m_delay);
        rd = (m_phase == 1) ? mfun(m_ea + 32'(2 * m_k)) : 8'h00;
        mem_ack   = ak;
        mem_rdata = rd;
        case (m_phase)
            0: if (st) begin
                m_dir  = opcode[7];
                m_long = opcode[6];
                m_dsel = opcode[11:9];
                m_ea   = areg_val + {{16{disp[15]}}, disp};
                m_hold = dreg_val;
                m_acc  = '0;
                m_k    = 0;
                m_wc   = 0;
                m_n    = m_long ? 4 : 2;
                m_phase = 1;
            end
            1: if (ak) begin
                m_acc = {m_acc[23:0], rd};
                m_k++;
                m_wc = 0;
                if (m_k == m_n) m_phase = 2;
            end else begin
                m_wc++;
            end
            default: m_phase = 0;
        endcase
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic do_op(logic [2:0] dr, logic [2:0] ar, bit dir, bit lng,
                         logic [31:0] aval, logic [31:0] dval, logic [15:0] dsp,
                         int delay, bit poke);
        opcode   = {4'b0000, dr, 1'b1, dir, lng, 3'b001, ar};
        areg_val = aval;
        dreg_val = dval;
        disp     = dsp;
        m_delay  = delay;
        tick(1'b1);
        while (m_phase != 0) begin
            if (poke) begin
                // R10: changed inputs and a fresh start while busy
                opcode   = opcode ^ 16'h0EC7;
                areg_val = ~areg_val;
                dreg_val = ~dreg_val;
                disp     = ~disp;
            end
            tick(poke);
        end
        tick(1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; opcode = '0; areg_val = '0; disp = '0;
        dreg_val = '0; mem_ack = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare();  // reset state
        // R6 long read, positive displacement, immediate ack
        do_op(3'd2, 3'd5, 1'b0, 1'b1, 32'h0000_1000, 32'hDEAD_BEEF, 16'h0004, 0, 1'b0);
        // R7 word read keeps upper half
        do_op(3'd6, 3'd1, 1'b0, 1'b0, 32'h0040_2000, 32'hCAFE_1234, 16'h0010, 1, 1'b0);
        // R3 R11 long write, negative displacement
        do_op(3'd1, 3'd3, 1'b1, 1'b1, 32'h0000_8000, 32'h1122_3344, 16'hFFFE, 2, 1'b0);
        // R3 word write sends low half, high byte first
        do_op(3'd7, 3'd0, 1'b1, 1'b0, 32'h0001_0001, 32'hAABB_CCDD, 16'h0000, 0, 1'b0);
        // R2 address wraps with large negative displacement
        do_op(3'd4, 3'd7, 1'b0, 1'b1, 32'h0000_0001, 32'h5555_AAAA, 16'h8000, 3, 1'b0);
        // R10 busy pokes during transfers
        do_op(3'd3, 3'd2, 1'b0, 1'b0, 32'h1234_5678, 32'h8765_4321, 16'h7FFF, 2, 1'b1);
        do_op(3'd5, 3'd6, 1'b1, 1'b1, 32'hFFFF_FFF0, 32'h0F1E_2D3C, 16'h0020, 1, 1'b1);
        for (int i = 0; i < 8; i++) begin
            do_op(3'(i), 3'(7 - i), i[0], i[1], 32'h0100_0000 * i + 32'h33,
                  32'h9E37_79B9 * (i + 1), 16'(16'h1357 * i), i % 4, i[2]);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule